// File: doc/BRIEF.md
# Shared Word Memory with Collision Arbitration

This block is a 2048-word by 16-bit memory that two independent requesters, called left and right, can reach at the same time through identical ports. Each port has a select, a write flag, two byte-lane write enables, an 11-bit word address, write data, registered read data and an active-low busy flag. The design runs on a single clock and is synchronous throughout.

Both ports can read freely, including from the same word in the same cycle. A collision occurs when both ports are selected on the same word and at least one of them writes. The port that arrived first keeps the word. The other port sees busy, and its writes are dropped until the winner releases its select. The busy flag can feed an interrupt or a wait input on the requester's side. Software that sees busy repeats its access once the flag clears.

Top module: `dpram_arb`

## Requirements
- R1: A write stores data at the addressed word. A read returns that word on the read data output after the next rising clock edge. Read data does not change in any cycle where the port is not selected.
- R2: Two reads in the same cycle, including reads of the same word, both return the stored word, and neither port shows busy.
- R3: When both ports are selected on the same word and at least one has the write flag set, exactly one port drives busy low. Both ports are never busy at the same time.
- R4: The port whose select rose in an earlier cycle wins the word. If both selects rose in the same cycle, the left port wins.
- R5: The losing port makes no change to memory while it is busy. The word keeps the winner's data.
- R6: Busy is low only while its own port is selected. It stays low through the cycle in which the winner's select falls and clears in the cycle after. The loser's retry then completes normally.
- R7: The high enable writes bits 15:8 and the low enable writes bits 7:0. A write with neither enable set leaves the word unchanged.
- R8: A read that loses in the collision cycle returns the word as it was before the winner's write in that cycle. The loser's read data then holds that value while the lock lasts.
- R9: After reset, both read data outputs are zero and both busy flags are high.
- R10: Accesses from the two ports to different words, writes included, never raise busy, and both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left port select |
| l_wr | input | 1 | Left write flag (1 = write, 0 = read) |
| l_hi_en | input | 1 | Left write enable for bits 15:8 |
| l_lo_en | input | 1 | Left write enable for bits 7:0 |
| l_addr | input | 11 | Left word address |
| l_wdat | input | 16 | Left write data |
| l_rdat | output | 16 | Left registered read data |
| l_busy_n | output | 1 | Left busy, active low |
| r_sel | input | 1 | Right port select |
| r_wr | input | 1 | Right write flag (1 = write, 0 = read) |
| r_hi_en | input | 1 | Right write enable for bits 15:8 |
| r_lo_en | input | 1 | Right write enable for bits 7:0 |
| r_addr | input | 11 | Right word address |
| r_wdat | input | 16 | Right write data |
| r_rdat | output | 16 | Right registered read data |
| r_busy_n | output | 1 | Right busy, active low |

## Verification
A full sweep writes an arithmetic pattern to every word through one port and reads it back through the other. This exposes address decoding and storage faults. A second full sweep reads every word from both ports at once, which separates harmless shared reads from real collisions. The collision cases cover a same-cycle tie, a right-first arrival with a later left write, and a losing read. Each case tells apart the winner choice, the drop of the loser's write, the one-cycle release delay and the pre-write read value. All four byte-enable combinations and simultaneous writes to distinct words complete the set.

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sel,
  input  logic          l_wr,
  input  logic          l_hi_en,
  input  logic          l_lo_en,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdat,
  output logic [DW-1:0] l_rdat,
  output logic          l_busy_n,
  input  logic          r_sel,
  input  logic          r_wr,
  input  logic          r_hi_en,
  input  logic          r_lo_en,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdat,
  output logic [DW-1:0] r_rdat,
  output logic          r_busy_n
);
  localparam int DEPTH = 1 << AW;
  localparam int HB    = DW / 2;

  logic [DW-1:0] mem [DEPTH];
  logic l_sel_q, r_sel_q;
  logic lk_l, lk_r;

  wire hit     = l_sel & r_sel & (l_addr == r_addr) & (l_wr | r_wr);
  wire free    = ~lk_l & ~lk_r;
  wire r_first = r_sel_q & ~l_sel_q;
  wire win_l   = free & hit & ~r_first;
  wire win_r   = free & hit & r_first;
  wire l_block = l_sel & (lk_r | win_r);
  wire r_block = r_sel & (lk_l | win_l);

  assign l_busy_n = ~l_block;
  assign r_busy_n = ~r_block;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_sel_q <= 1'b0;
      r_sel_q <= 1'b0;
      lk_l    <= 1'b0;
      lk_r    <= 1'b0;
    end else begin
      l_sel_q <= l_sel;
      r_sel_q <= r_sel;
      lk_l    <= lk_l ? l_sel : win_l;
      lk_r    <= lk_r ? r_sel : win_r;
    end
  end

  always_ff @(posedge clk) begin
    if (l_sel & l_wr & ~l_block) begin
      if (l_hi_en) mem[l_addr][DW-1:HB] <= l_wdat[DW-1:HB];
      if (l_lo_en) mem[l_addr][HB-1:0]  <= l_wdat[HB-1:0];
    end
    if (r_sel & r_wr & ~r_block) begin
      if (r_hi_en) mem[r_addr][DW-1:HB] <= r_wdat[DW-1:HB];
      if (r_lo_en) mem[r_addr][HB-1:0]  <= r_wdat[HB-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_rdat <= '0;
      r_rdat <= '0;
    end else begin
      if (l_sel & ~l_wr & ~lk_r) l_rdat <= mem[l_addr];
      if (r_sel & ~r_wr & ~lk_l) r_rdat <= mem[r_addr];
    end
  end
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_sel,
  input logic          l_wr,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_rdat,
  input logic          l_busy_n,
  input logic          r_sel,
  input logic          r_wr,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] r_rdat,
  input logic          r_busy_n,
  input logic          lk_l,
  input logic          lk_r
);
  p_one_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n));

  p_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (l_sel && r_sel && l_addr == r_addr && (l_wr || r_wr)) |-> (l_busy_n != r_busy_n));

  p_tie_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(l_sel) && $rose(r_sel) && l_addr == r_addr && (l_wr || r_wr))
      |-> (l_busy_n && !r_busy_n));

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_l && !l_sel) |=> (r_busy_n || l_sel));

  p_busy_sel_l_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !l_busy_n |-> l_sel);

  p_busy_sel_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !r_busy_n |-> r_sel);

  p_diff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (l_sel && r_sel && l_addr != r_addr && !lk_l && !lk_r) |-> (l_busy_n && r_busy_n));

  p_idle_l_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !l_sel |=> $stable(l_rdat));

  p_idle_r_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !r_sel |=> $stable(r_rdat));

  p_loser_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_l |=> $stable(r_rdat));
endmodule

bind dpram_arb dpram_arb_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr), .l_rdat(l_rdat), .l_busy_n(l_busy_n),
  .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr), .r_rdat(r_rdat), .r_busy_n(r_busy_n),
  .lk_l(lk_l), .lk_r(lk_r)
);

// File: tb/dpram_arb_bench.sv
`timescale 1ns/1ps
module dpram_arb_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sel = 0, l_wr = 0, l_hi_en = 0, l_lo_en = 0;
  logic r_sel = 0, r_wr = 0, r_hi_en = 0, r_lo_en = 0;
  logic [10:0] l_addr = '0, r_addr = '0;
  logic [15:0] l_wdat = '0, r_wdat = '0;
  logic [15:0] l_rdat, r_rdat;
  logic l_busy_n, r_busy_n;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  dpram_arb u_dpram_arb (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_wr(l_wr), .l_hi_en(l_hi_en), .l_lo_en(l_lo_en),
    .l_addr(l_addr), .l_wdat(l_wdat), .l_rdat(l_rdat), .l_busy_n(l_busy_n),
    .r_sel(r_sel), .r_wr(r_wr), .r_hi_en(r_hi_en), .r_lo_en(r_lo_en),
    .r_addr(r_addr), .r_wdat(r_wdat), .r_rdat(r_rdat), .r_busy_n(r_busy_n)
  );

  function automatic logic [15:0] pat(int a);
    return 16'((a * 40503) ^ 16'h5A5A);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_sel = 0; l_wr = 0; l_hi_en = 0; l_lo_en = 0;
    r_sel = 0; r_wr = 0; r_hi_en = 0; r_lo_en = 0;
  endtask

  task automatic wr_l(input int a, input logic [15:0] d, input logic hi, input logic lo);
    l_sel = 1; l_wr = 1; l_hi_en = hi; l_lo_en = lo; l_addr = 11'(a); l_wdat = d;
    step();
    idle();
  endtask

  task automatic rd_r(input int a, output logic [15:0] d);
    r_sel = 1; r_wr = 0; r_addr = 11'(a);
    step();
    d = r_rdat;
    idle();
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) step();
    check("R9 l_rdat", l_rdat, 16'h0);
    check("R9 r_rdat", r_rdat, 16'h0);
    check("R9 l_busy_n", {15'b0, l_busy_n}, 16'h1);
    check("R9 r_busy_n", {15'b0, r_busy_n}, 16'h1);
    rst_n = 1;
    step();

    // R1: fill through left, read back through right
    l_sel = 1; l_wr = 1; l_hi_en = 1; l_lo_en = 1;
    for (int a = 0; a < 2048; a++) begin
      l_addr = 11'(a); l_wdat = pat(a);
      step();
    end
    idle();
    step();
    check("R1 idle hold", r_rdat, 16'h0);
    r_sel = 1; r_wr = 0;
    for (int a = 0; a < 2048; a++) begin
      r_addr = 11'(a);
      step();
      check("R1 readback", r_rdat, pat(a));
    end
    idle();
    step();

    // R2: both ports read the same word together
    l_sel = 1; r_sel = 1;
    for (int a = 0; a < 2048; a++) begin
      l_addr = 11'(a); r_addr = 11'(a);
      #1;
      check("R2 l_busy_n", {15'b0, l_busy_n}, 16'h1);
      check("R2 r_busy_n", {15'b0, r_busy_n}, 16'h1);
      step();
      check("R2 l_rdat", l_rdat, pat(a));
      check("R2 r_rdat", r_rdat, pat(a));
    end
    idle();
    step();

    // R7: byte lanes
    for (int c = 0; c < 4; c++) begin
      wr_l(400 + c, 16'h1234, 1, 1);
      wr_l(400 + c, 16'hABCD, c[1], c[0]);
      rd_r(400 + c, v);
      check("R7 byte lanes", v, {c[1] ? 8'hAB : 8'h12, c[0] ? 8'hCD : 8'h34});
    end
    step();

    // R3 R4 R5: same-cycle tie, left wins
    l_sel = 1; l_wr = 1; l_hi_en = 1; l_lo_en = 1; l_addr = 11'd100; l_wdat = 16'h1111;
    r_sel = 1; r_wr = 1; r_hi_en = 1; r_lo_en = 1; r_addr = 11'd100; r_wdat = 16'h2222;
    #1;
    check("R4 tie left not busy", {15'b0, l_busy_n}, 16'h1);
    check("R3 tie right busy", {15'b0, r_busy_n}, 16'h0);
    step();
    check("R3 right stays busy", {15'b0, r_busy_n}, 16'h0);
    idle();
    step();
    rd_r(100, v);
    check("R5 loser write dropped", v, 16'h1111);
    step();

    // R4 R6: right arrives first, left loses then retries
    r_sel = 1; r_wr = 1; r_hi_en = 1; r_lo_en = 1; r_addr = 11'd101; r_wdat = 16'h3333;
    step();
    l_sel = 1; l_wr = 1; l_hi_en = 1; l_lo_en = 1; l_addr = 11'd101; l_wdat = 16'h4444;
    #1;
    check("R4 earlier right wins", {15'b0, l_busy_n}, 16'h0);
    check("R4 right not busy", {15'b0, r_busy_n}, 16'h1);
    step();
    check("R6 left busy while held", {15'b0, l_busy_n}, 16'h0);
    r_sel = 0; r_wr = 0;
    #1;
    check("R6 busy in drop cycle", {15'b0, l_busy_n}, 16'h0);
    step();
    check("R6 busy clears next cycle", {15'b0, l_busy_n}, 16'h1);
    step();
    idle();
    rd_r(101, v);
    check("R6 retry lands", v, 16'h4444);
    step();

    // R5: right wins, both release together
    r_sel = 1; r_wr = 1; r_hi_en = 1; r_lo_en = 1; r_addr = 11'd102; r_wdat = 16'h5555;
    step();
    l_sel = 1; l_wr = 1; l_hi_en = 1; l_lo_en = 1; l_addr = 11'd102; l_wdat = 16'h6666;
    step();
    idle();
    step();
    rd_r(102, v);
    check("R5 right winner kept", v, 16'h5555);
    step();

    // R8: losing read sees the pre-write word and holds it
    l_sel = 1; l_wr = 1; l_hi_en = 1; l_lo_en = 1; l_addr = 11'd200; l_wdat = 16'hBEEF;
    r_sel = 1; r_wr = 0; r_addr = 11'd200;
    step();
    check("R8 old value", r_rdat, pat(200));
    step();
    check("R8 held while locked", r_rdat, pat(200));
    l_sel = 0; l_wr = 0;
    step();
    check("R8 held in drop cycle", r_rdat, pat(200));
    step();
    check("R8 fresh after release", r_rdat, 16'hBEEF);
    idle();
    step();

    // R10: different words, both write
    l_sel = 1; l_wr = 1; l_hi_en = 1; l_lo_en = 1; l_addr = 11'd300; l_wdat = 16'h7777;
    r_sel = 1; r_wr = 1; r_hi_en = 1; r_lo_en = 1; r_addr = 11'd301; r_wdat = 16'h8888;
    #1;
    check("R10 l_busy_n", {15'b0, l_busy_n}, 16'h1);
    check("R10 r_busy_n", {15'b0, r_busy_n}, 16'h1);
    step();
    idle();
    step();
    rd_r(300, v);
    check("R10 left word", v, 16'h7777);
    rd_r(301, v);
    check("R10 right word", v, 16'h8888);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule